// File: doc/BRIEF.md
# Frame-Synchronised BPSK Bit-Error Counter

This block sits behind a BPSK receiver's symbol decision stage and measures link quality against a frame whose content is known in advance. Hard-decision bits arrive as a valid/data pair. After a start pulse the block searches the incoming stream for the opening bits of the reference frame. It then compares every following bit with the reference, position by position, and counts mismatches over the whole frame. It also counts mismatches over the payload section alone.

Alignment comes from a sliding correlator. The correlator compares the eight most recent bits with the first eight reference bits. The frame opens with a run of five equal bits, so a shorter window could match while still inside that run and settle one or more bits early. The eight-bit window reaches past the run into the first transition, so it can match at only one place: the real frame start. Once that match occurs, its alignment alone decides which reference bit each later bit is compared with.

A run ends in one of two ways. It completes when the configured number of frame bits has been counted, which raises a done flag. It is abandoned when a fixed cycle budget runs out first, which raises a timed-out flag. Software, or a sequencer, reads the counts once either flag is high.

Top module: `ber_frame_sync`

## Requirements
- R1: After reset, `active`, `done` and `timedOut` are 0, and `rxCount`, `totalErr` and `payloadErr` are 0.
- R2: A rising edge on `startIn` raises `active` in the following cycle, clears all counts, flags and lock state (also in the middle of a frame), and latches `cfgFrameLen`; later changes to `cfgFrameLen` have no effect until the next start edge.
- R3: Bit i of `refFrame` is frame bit i, with bit 0 sent first. Lock occurs on the valid bit that completes an 8-bit window equal to frame bits 0..7 (0,0,0,0,0,1,1,0), oldest bit first. A stream with only four leading zeros, or with zeros followed by anything other than 1,1,0, never locks. Any number of leading non-matching bits does not shift the alignment. At lock, `rxCount` becomes 8 and the error counts stay 0.
- R4: After lock, each valid bit is compared with the reference bit at the next frame index. `rxCount` increments by 1 per bit, and `totalErr` increments by 1 per mismatch.
- R5: `payloadErr` counts only mismatches at frame index 25 or higher, which is the last 256 bits of the 281-bit frame. Mismatches at indices 8..24 raise `totalErr` only.
- R6: When `rxCount` reaches the latched frame length, `active` falls and `done` rises in the same cycle. Bits that arrive after that leave every count unchanged.
- R7: If the frame is not complete `TIMEOUT` cycles after the start edge, `active` falls, `timedOut` rises and `done` stays 0. If lock never occurred, all counts remain 0; otherwise the counts reached so far are kept.
- R8: A cycle with `bitValid` low is ignored whatever `bitData` is.
- R9: Before the first start edge the latched frame length is 0 and no incoming bit changes any count or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Arming request; its rising edge starts a run |
| cfgFrameLen | input | 9 | Number of frame bits to count, latched on the start edge |
| refFrame | input | 281 | Reference frame, bit i is frame bit i |
| bitValid | input | 1 | Qualifies `bitData` |
| bitData | input | 1 | Hard-decision received bit |
| active | output | 1 | A run is in progress |
| done | output | 1 | The last run completed the full frame |
| timedOut | output | 1 | The last run ran out of its cycle budget |
| rxCount | output | 9 | Received frame bits, including the 8 lock-window bits |
| totalErr | output | 9 | Mismatches over the whole frame |
| payloadErr | output | 9 | Mismatches over the payload section |

## Verification
Frames are sent after different leading runs of junk: none, all zeros, alternating bits and all ones. An early or late lock would show up as a nonzero error count on an otherwise clean frame. Single and paired bit errors are placed on both sides of the header/payload boundary (indices 24 and 25) and at the first and last compared bits. This separates total from payload counting and catches off-by-one indexing. A repeating 0,0,0,0,1,1,1,1 stream is sent to show that a short window would lock where this one must not. Directed runs cover the cycle-exact timeout, a stall after lock, a short configured length, a configuration change after the start edge, and a restart in mid-frame.

// File: rtl/ber_sync_pkg.sv
package ber_sync_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_TRACK  = 2'd2
  } syncState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clearAll;  // start edge: wipe counts, window, latch length
    logic shiftEn;   // push a bit into the lock window
    logic lockNow;   // the window just matched
    logic countEn;   // compare and count one aligned bit
  } ctlStrobe_t;

endpackage

// File: rtl/ber_sync_ctrl.sv
module ber_sync_ctrl
  import ber_sync_pkg::*;
#(
  parameter int TIMEOUT = 1048576
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       bitValid,
  input  logic       matchNow,
  input  logic       lastBit,
  input  logic       lockFull,
  output ctlStrobe_t strb,
  output logic       active,
  output logic       done,
  output logic       timedOut
);

  localparam int TMR_W = $clog2(TIMEOUT + 1);

  syncState_t       state;
  logic             startPrev;
  logic             startEdge;
  logic [TMR_W-1:0] timer;
  logic             finishNow;
  logic             expireNow;

  assign startEdge = startIn && !startPrev;
  assign active    = (state != ST_IDLE);

  always_comb begin
    strb = '0;
    if (startEdge) begin
      strb.clearAll = 1'b1;
    end else begin
      case (state)
        ST_SEARCH: begin
          strb.shiftEn = bitValid;
          strb.lockNow = matchNow;
        end
        ST_TRACK:  strb.countEn = bitValid;
        default:   ;
      endcase
    end
  end

  assign finishNow = ((state == ST_SEARCH) && matchNow && lockFull) ||
                     ((state == ST_TRACK) && bitValid && lastBit);
  assign expireNow = active && (timer == TMR_W'(TIMEOUT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      startPrev <= 1'b0;
      timer     <= '0;
      done      <= 1'b0;
      timedOut  <= 1'b0;
    end else begin
      startPrev <= startIn;
      if (startEdge) begin
        state    <= ST_SEARCH;
        timer    <= '0;
        done     <= 1'b0;
        timedOut <= 1'b0;
      end else if (active) begin
        if (finishNow) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else if (expireNow) begin
          state    <= ST_IDLE;
          timedOut <= 1'b1;
        end else begin
          timer <= timer + 1'b1;
          if (state == ST_SEARCH && matchNow) state <= ST_TRACK;
        end
      end
    end
  end

  // R7: a run ends in exactly one way
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timedOut));

  // R2: a start edge always arms a clean run
  assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rstN)
    startEdge |=> (active && !done && !timedOut));

  // R7: the cycle budget is never overrun while active
  assert_timer_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (timer < TMR_W'(TIMEOUT)));

  // R6: a finished run is no longer active
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !active);

endmodule

// File: rtl/ber_sync_datapath.sv
module ber_sync_datapath
  import ber_sync_pkg::*;
#(
  parameter int FRAME_LEN   = 281,
  parameter int PAYLOAD_LEN = 256,
  parameter int LOCK_BITS   = 8,
  parameter int CNT_W       = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strb,
  input  logic [CNT_W-1:0]     cfgFrameLen,
  input  logic [FRAME_LEN-1:0] refFrame,
  input  logic                 bitValid,
  input  logic                 bitData,
  output logic                 matchNow,
  output logic                 lastBit,
  output logic                 lockFull,
  output logic [CNT_W-1:0]     rxCount,
  output logic [CNT_W-1:0]     totalErr,
  output logic [CNT_W-1:0]     payloadErr
);

  localparam int HDR_LEN = FRAME_LEN - PAYLOAD_LEN;
  localparam int FILL_W  = $clog2(LOCK_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LOCK_BITS-1:0] winReg;
  logic [LOCK_BITS-1:0] winNext;
  logic [LOCK_BITS-1:0] lockPattern;
  logic [FILL_W-1:0]    fillCnt;
  logic                 windowReady;
  logic [CNT_W-1:0]     frameLenReg;
  logic [CNT_W-1:0]     bitIdx;
  logic                 refBit;
  logic                 mismatch;
  logic                 inPayload;

  // oldest window bit sits at the top and lines up with frame bit 0
  always_comb begin
    for (int i = 0; i < LOCK_BITS; i++) begin
      lockPattern[LOCK_BITS-1-i] = refFrame[i];
    end
  end

  assign winNext     = {winReg[LOCK_BITS-2:0], bitData};
  assign windowReady = (fillCnt == FILL_W'(LOCK_BITS - 1));
  assign matchNow    = bitValid && windowReady && (winNext == lockPattern);

  assign refBit    = (bitIdx < CNT_W'(FRAME_LEN)) ? refFrame[bitIdx] : 1'b0;
  assign mismatch  = bitData ^ refBit;
  assign inPayload = (bitIdx >= CNT_W'(HDR_LEN));

  assign lastBit  = ({1'b0, rxCount} + 1'b1) >= {1'b0, frameLenReg};
  assign lockFull = ({1'b0, frameLenReg} <= (CNT_W + 1)'(LOCK_BITS));

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winReg      <= '0;
      fillCnt     <= '0;
      frameLenReg <= '0;
      bitIdx      <= '0;
      rxCount     <= '0;
      totalErr    <= '0;
      payloadErr  <= '0;
    end else if (strb.clearAll) begin
      winReg      <= '0;
      fillCnt     <= '0;
      frameLenReg <= cfgFrameLen;
      bitIdx      <= '0;
      rxCount     <= '0;
      totalErr    <= '0;
      payloadErr  <= '0;
    end else begin
      if (strb.shiftEn) begin
        winReg <= winNext;
        if (!windowReady) fillCnt <= fillCnt + 1'b1;
      end
      if (strb.lockNow) begin
        // the matched window counts as error-free received bits
        rxCount <= CNT_W'(LOCK_BITS);
        bitIdx  <= CNT_W'(LOCK_BITS);
      end
      if (strb.countEn) begin
        rxCount <= satInc(rxCount);
        bitIdx  <= satInc(bitIdx);
        if (mismatch) begin
          totalErr <= satInc(totalErr);
          if (inPayload) payloadErr <= satInc(payloadErr);
        end
      end
    end
  end

  // R5: payload mismatches are a subset of all mismatches
  assert_payload_subset_R5: assert property (@(posedge clk) disable iff (!rstN)
    payloadErr <= totalErr);

  // R4: never more errors than compared bits
  assert_err_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    totalErr <= rxCount);

  // R3: lock credits exactly the window with no errors
  assert_lock_credit_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.lockNow |=> (rxCount == CNT_W'(LOCK_BITS) && totalErr == '0));

  // R8: a bit without valid changes no count
  assert_invalid_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !strb.clearAll) |=> $stable(rxCount) && $stable(totalErr));

endmodule

// File: rtl/ber_frame_sync.sv
module ber_frame_sync
  import ber_sync_pkg::*;
#(
  parameter int FRAME_LEN   = 281,
  parameter int PAYLOAD_LEN = 256,
  parameter int LOCK_BITS   = 8,
  parameter int TIMEOUT     = 1048576,
  localparam int CNT_W      = $clog2(FRAME_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  input  logic [CNT_W-1:0]     cfgFrameLen,
  input  logic [FRAME_LEN-1:0] refFrame,
  input  logic                 bitValid,
  input  logic                 bitData,
  output logic                 active,
  output logic                 done,
  output logic                 timedOut,
  output logic [CNT_W-1:0]     rxCount,
  output logic [CNT_W-1:0]     totalErr,
  output logic [CNT_W-1:0]     payloadErr
);

  ctlStrobe_t strb;
  logic       matchNow;
  logic       lastBit;
  logic       lockFull;

  ber_sync_ctrl #(
    .TIMEOUT (TIMEOUT)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .bitValid (bitValid),
    .matchNow (matchNow),
    .lastBit  (lastBit),
    .lockFull (lockFull),
    .strb     (strb),
    .active   (active),
    .done     (done),
    .timedOut (timedOut)
  );

  ber_sync_datapath #(
    .FRAME_LEN   (FRAME_LEN),
    .PAYLOAD_LEN (PAYLOAD_LEN),
    .LOCK_BITS   (LOCK_BITS),
    .CNT_W       (CNT_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgFrameLen (cfgFrameLen),
    .refFrame    (refFrame),
    .bitValid    (bitValid),
    .bitData     (bitData),
    .matchNow    (matchNow),
    .lastBit     (lastBit),
    .lockFull    (lockFull),
    .rxCount     (rxCount),
    .totalErr    (totalErr),
    .payloadErr  (payloadErr)
  );

  // R9: nothing is counted while idle
  assert_idle_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !startIn) |=> $stable(rxCount));

endmodule

// File: tb/tb_ber_frame_sync.sv
module tb_ber_frame_sync;

  localparam int FL  = 281;
  localparam int TMO = 1500;
  localparam int NONE = 511;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startIn = 1'b0;
  logic [8:0]    cfgFrameLen = 9'd281;
  logic [FL-1:0] refFrame;
  logic          bitValid = 1'b0;
  logic          bitData = 1'b0;
  logic          active, done, timedOut;
  logic [8:0]    rxCount, totalErr, payloadErr;

  int nChecks = 0;
  int nBad = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ber_frame_sync #(.TIMEOUT(TMO)) dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .cfgFrameLen(cfgFrameLen),
    .refFrame(refFrame), .bitValid(bitValid), .bitData(bitData),
    .active(active), .done(done), .timedOut(timedOut),
    .rxCount(rxCount), .totalErr(totalErr), .payloadErr(payloadErr));

  typedef struct packed {
    logic [4:0]  leadLen;
    logic [15:0] leadBits;
    logic [8:0]  errA;
    logic [8:0]  errB;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{5'd0, 16'h0000, 9'd511, 9'd511},
    '{5'd3, 16'h0000, 9'd511, 9'd511},
    '{5'd6, 16'h0015, 9'd10,  9'd511},
    '{5'd4, 16'h000F, 9'd25,  9'd511},
    '{5'd2, 16'h0001, 9'd24,  9'd280},
    '{5'd7, 16'h0000, 9'd8,   9'd100}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sendBit(input logic v, input logic d);
    @(negedge clk);
    bitValid = v;
    bitData  = d;
  endtask

  task automatic settle();
    @(negedge clk);
    bitValid = 1'b0;
    bitData  = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic sendFrame(input int nBits, input int errA, input int errB,
                           input bit gaps);
    for (int i = 0; i < nBits; i++) begin
      if (gaps && (i % 7 == 3)) sendBit(1'b0, ~refFrame[i]);
      sendBit(1'b1, refFrame[i] ^ ((i == errA) || (i == errB)));
    end
    settle();
  endtask

  task automatic waitIdle(output int cnt);
    cnt = 0;
    while (active && cnt < TMO + 20) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      nBad = nBad + 1;
      nChecks = nChecks + 1;
      $display("FAIL watchdog: got %0d expected %0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    logic [8:0] lfsr;
    int cnt;
    lfsr = 9'h1A5;
    for (int i = 0; i < FL; i++) begin
      if (i < 12) refFrame[i] = 12'b1010_0110_0000 >> i;
      else begin
        refFrame[i] = lfsr[0];
        lfsr = {lfsr[0] ^ lfsr[4], lfsr[8:1]};
      end
    end

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!active && !done && !timedOut, "R1", "flags", {active, done, timedOut}, 0);
    check(rxCount == 0 && totalErr == 0 && payloadErr == 0, "R1", "counts",
          rxCount + totalErr + payloadErr, 0);

    // R9 bits before any start
    sendFrame(40, NONE, NONE, 0);
    check(rxCount == 0 && !active && !done, "R9", "pre-start rxCount", rxCount, 0);

    // table-driven frames: R3 R4 R5 R6 R8
    for (int v = 0; v < 6; v++) begin
      int expTot, expPay;
      expTot = 0; expPay = 0;
      if (VEC[v].errA != NONE) begin expTot++; if (VEC[v].errA >= 25) expPay++; end
      if (VEC[v].errB != NONE) begin expTot++; if (VEC[v].errB >= 25) expPay++; end
      pulseStart();
      check(active && rxCount == 0 && !done, "R2", "armed", active, 1);
      for (int j = 0; j < VEC[v].leadLen; j++) sendBit(1'b1, VEC[v].leadBits[j]);
      sendFrame(FL, VEC[v].errA, VEC[v].errB, 1);
      check(done && !active && !timedOut, "R6", "done flag", done, 1);
      check(rxCount == FL, "R3", "rxCount", rxCount, FL);
      check(totalErr == expTot, "R4", "totalErr", totalErr, expTot);
      check(payloadErr == expPay, "R5", "payloadErr", payloadErr, expPay);
    end

    // R6 short frame, then extra bits ignored
    cfgFrameLen = 9'd40;
    pulseStart();
    sendFrame(FL, 100, NONE, 0);
    check(done && rxCount == 40, "R6", "short rxCount", rxCount, 40);
    check(totalErr == 0, "R6", "bits after done ignored", totalErr, 0);

    // R2 length latched only on the start edge
    cfgFrameLen = 9'd281;
    pulseStart();
    cfgFrameLen = 9'd50;
    sendFrame(FL, NONE, NONE, 0);
    check(done && rxCount == FL, "R2", "latched length", rxCount, FL);
    cfgFrameLen = 9'd281;

    // R2 restart mid-frame
    pulseStart();
    sendFrame(100, 60, NONE, 0);
    pulseStart();
    check(active && !done && rxCount == 0 && totalErr == 0, "R2", "restart clear",
          rxCount, 0);
    sendFrame(FL, NONE, NONE, 0);
    check(done && rxCount == FL && totalErr == 0, "R2", "after restart", totalErr, 0);

    // R7 exact budget with no input
    pulseStart();
    waitIdle(cnt);
    check(cnt == TMO, "R7", "active cycles", cnt, TMO);
    check(timedOut && !done && rxCount == 0, "R7", "no-lock timeout", timedOut, 1);

    // R3 four zeros then ones must never lock
    pulseStart();
    for (int i = 0; i < 200; i++) sendBit(1'b1, (i % 8) >= 4);
    settle();
    check(rxCount == 0 && active, "R3", "no short-window lock", rxCount, 0);
    waitIdle(cnt);
    check(timedOut && !done && totalErr == 0, "R7", "timeout after junk", timedOut, 1);

    // R7 stall after lock keeps partial counts
    pulseStart();
    sendFrame(50, 30, NONE, 0);
    waitIdle(cnt);
    check(timedOut && !done, "R7", "stall timeout flag", timedOut, 1);
    check(rxCount == 50 && totalErr == 1 && payloadErr == 1, "R7", "partial rxCount",
          rxCount, 50);

    finished = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule